// File: doc/BRIEF.md
# VLIW Execute-Set Dispatcher

This block sits between instruction fetch and the execution slots of an eight-wide VLIW core. It accepts one 256-bit fetch packet at a time over a valid/ready handshake. Each packet holds eight 32-bit instruction words. The block walks the packet from slot 0 upward and cuts it into execute sets, using a chaining bit carried in every word. It then presents one set per clock on an eight-slot issue bus. Every slot of that bus has its own valid flag.

Every word also carries a predicate field. That field names an entry of a small condition register file and says whether the instruction runs when that entry is zero or when it is nonzero. An instruction whose predicate fails keeps its slot position and its word on the bus, but its valid flag is cleared. Software fills the condition registers through a simple write port. A downstream stall input freezes issue without losing the current position in the packet.

Top module: `vliw_dispatch`

## Requirements
- R1: After synchronous reset, every issue valid flag is 0, the issue word bus is 0, `pkt_ready` is 1, and all condition registers read as zero.
- R2: A packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both 1. From the following cycle `pkt_ready` stays 0 until the last set of that packet has issued. No slot is valid unless a packet was held in the previous cycle.
- R3: Bit 0 of each word is the chaining bit. A set starts at the first unissued slot and runs up to and including the first slot whose chaining bit is 0. For example, chaining bits 1,1,1,0,1,0,1,0 for slots 0..7 give issue masks 0x0F, 0x30 and 0xC0 on three consecutive cycles.
- R4: The chaining bit of slot 7 is ignored. A set never runs past slot 7, so all chaining bits at 1 give a single mask of 0xFF.
- R5: One set issues per unstalled cycle. Word k of the packet appears on issue slot k (bits 32k+31..32k), and slots outside the current set show valid 0 and word 0.
- R6: While `stall` is 1 at a clock edge, no set issues. The next cycle shows all valid flags 0, and the position within the packet is kept.
- R7: Bits 31:29 of a word name a condition register and bit 28 picks the sense. Sense 1 means the word runs when the register is zero, and sense 0 means it runs when the register is nonzero. Index 0 means the word always runs, whatever bit 28 holds.
- R8: A word whose predicate fails is still driven on its slot's word bus, with its valid flag 0. Other slots of the same set are unaffected.
- R9: A condition register write taken at clock edge N is seen by sets issued at edge N+1 and later, but not by a set issued at edge N itself.
- R10: `pkt_ready` returns to 1 in the cycle right after the last set of a packet issues. The first set of a new packet issues at the clock edge after the one that accepted it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pkt_valid | input | 1 | Fetch packet offered |
| pkt_ready | output | 1 | Block can take a packet |
| pkt_data | input | 256 | Eight instruction words, slot k in bits 32k+31..32k |
| stall | input | 1 | Downstream hold; no set issues while high |
| cr_we | input | 1 | Condition register write enable |
| cr_waddr | input | 3 | Condition register index |
| cr_wdata | input | 32 | Condition register write value |
| iss_valid | output | 8 | Per-slot valid flag of the issued set |
| iss_instr | output | 256 | Per-slot instruction word, slot k in bits 32k+31..32k |

## Verification
The delicate overlap is a condition register write landing on the same clock edge at which a set issues with a word predicated on that register. The bench offers a two-set packet and writes the register exactly on the first issue edge. It expects the first set to be judged with the old value and the second set with the new one. A behavioural model that applies writes after evaluating predicates judges the same overlap during a long random phase. In that phase writes, stalls and packet offers collide freely, and the model is compared with the outputs on every clock.

// File: rtl/vliw_dispatch_pkg.sv
package vliw_dispatch_pkg;

  // position of the set-chaining flag inside a word
  localparam int CHAIN_POS = 0;
  // predicate field: register index above a one-bit sense flag
  localparam int CREG_W    = 3;
  localparam int PRED_W    = CREG_W + 1;

  typedef struct packed {
    logic [CREG_W-1:0] creg;
    logic              on_zero;
  } pred_field_t;

  // true when the word must execute, given whether its register is zero
  function automatic logic pred_holds(input pred_field_t f, input logic sel_zero);
    if (f.creg == '0) return 1'b1;
    return f.on_zero ? sel_zero : !sel_zero;
  endfunction

endpackage

// File: rtl/vd_cond_file.sv
module vd_cond_file #(
  parameter int NREG = 8,
  parameter int DW   = 32,
  parameter int AW   = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            we,
  input  logic [AW-1:0]   waddr,
  input  logic [DW-1:0]   wdata,
  output logic [NREG-1:0] is_zero
);

  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_zero
      assign is_zero[g] = (mem[g] == '0);
    end
  endgenerate

  // a write becomes visible one edge later
  assert_write_visible_R9: assert property (@(posedge clk) disable iff (rst)
    we |=> (is_zero[$past(waddr)] == ($past(wdata) == '0)));

endmodule

// File: rtl/vd_set_select.sv
module vd_set_select #(
  parameter int SLOTS = 8,
  parameter int SW    = $clog2(SLOTS)
) (
  input  logic [SW-1:0]    start,
  input  logic [SLOTS-1:0] chain,
  output logic [SLOTS-1:0] mask,
  output logic             is_last,
  output logic [SW-1:0]    nxt
);

  always_comb begin
    logic open_s;
    logic closed_s;
    mask     = '0;
    is_last  = 1'b0;
    nxt      = '0;
    open_s   = 1'b0;
    closed_s = 1'b0;
    for (int k = 0; k < SLOTS; k++) begin
      if (!closed_s && (SW'(k) == start)) open_s = 1'b1;
      if (open_s && !closed_s) begin
        mask[k] = 1'b1;
        if (!chain[k] || (k == SLOTS - 1)) begin
          closed_s = 1'b1;
          is_last  = (k == SLOTS - 1);
          nxt      = SW'(k + 1);
        end
      end
    end
  end

endmodule

// File: rtl/vd_pred_eval.sv
module vd_pred_eval
  import vliw_dispatch_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int NREG  = 1 << CREG_W
) (
  input  logic [SLOTS*IW-1:0] words,
  input  logic [NREG-1:0]     is_zero,
  output logic [SLOTS-1:0]    pass
);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      pred_field_t f;
      assign f       = words[g*IW+IW-1 -: PRED_W];
      assign pass[g] = pred_holds(f, is_zero[f.creg]);
    end
  endgenerate

endmodule

// File: rtl/vliw_dispatch.sv
module vliw_dispatch
  import vliw_dispatch_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int IW    = 32,
  parameter int CR_DW = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                pkt_valid,
  output logic                pkt_ready,
  input  logic [SLOTS*IW-1:0] pkt_data,
  input  logic                stall,
  input  logic                cr_we,
  input  logic [CREG_W-1:0]   cr_waddr,
  input  logic [CR_DW-1:0]    cr_wdata,
  output logic [SLOTS-1:0]    iss_valid,
  output logic [SLOTS*IW-1:0] iss_instr
);

  localparam int PKT_W = SLOTS * IW;
  localparam int SW    = $clog2(SLOTS);
  localparam int NREG  = 1 << CREG_W;

  logic [PKT_W-1:0] pkt_q;
  logic             held_q;
  logic [SW-1:0]    start_q;

  logic [SLOTS-1:0] chain;
  logic [SLOTS-1:0] set_mask;
  logic             set_last;
  logic [SW-1:0]    set_next;
  logic [NREG-1:0]  cr_zero;
  logic [SLOTS-1:0] pred_pass;
  logic [PKT_W-1:0] masked_words;
  logic             fire;

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_lane
      assign chain[g] = pkt_q[g*IW+CHAIN_POS];
      assign masked_words[g*IW +: IW] = set_mask[g] ? pkt_q[g*IW +: IW] : '0;
    end
  endgenerate

  vd_cond_file #(.NREG(NREG), .DW(CR_DW)) u_cond (
    .clk(clk), .rst(rst), .we(cr_we), .waddr(cr_waddr),
    .wdata(cr_wdata), .is_zero(cr_zero)
  );

  vd_set_select #(.SLOTS(SLOTS)) u_sel (
    .start(start_q), .chain(chain), .mask(set_mask),
    .is_last(set_last), .nxt(set_next)
  );

  vd_pred_eval #(.SLOTS(SLOTS), .IW(IW), .NREG(NREG)) u_pred (
    .words(pkt_q), .is_zero(cr_zero), .pass(pred_pass)
  );

  assign fire      = held_q && !stall;
  assign pkt_ready = !held_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pkt_q     <= '0;
      held_q    <= 1'b0;
      start_q   <= '0;
      iss_valid <= '0;
      iss_instr <= '0;
    end else begin
      iss_valid <= '0;
      iss_instr <= '0;
      if (fire) begin
        iss_valid <= set_mask & pred_pass;
        iss_instr <= masked_words;
        if (set_last) begin
          held_q  <= 1'b0;
          start_q <= '0;
        end else begin
          start_q <= set_next;
        end
      end else if (pkt_valid && !held_q) begin
        pkt_q   <= pkt_data;
        held_q  <= 1'b1;
        start_q <= '0;
      end
    end
  end

  // an accepted packet blocks the next one
  assert_accept_blocks_R2: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready) |=> !pkt_ready);

  // issue only out of a held packet
  assert_issue_needs_packet_R2: assert property (@(posedge clk) disable iff (rst)
    (iss_valid != '0) |-> $past(!pkt_ready));

  // the resume point always opens the current set
  assert_start_in_set_R3: assert property (@(posedge clk) disable iff (rst)
    held_q |-> set_mask[start_q]);

  // stall freezes issue
  assert_stall_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    stall |=> (iss_valid == '0));

  // finishing a packet reopens the input
  assert_last_frees_R10: assert property (@(posedge clk) disable iff (rst)
    (fire && set_last) |=> pkt_ready);

  generate
    for (genvar g = 0; g < SLOTS; g++) begin : g_chk
      // an unconditional word in the issuing set is always valid
      assert_uncond_issue_R7: assert property (@(posedge clk) disable iff (rst)
        (fire && set_mask[g] && (pkt_q[g*IW+IW-1 -: CREG_W] == '0)) |=> iss_valid[g]);
    end
  endgenerate

endmodule

// File: tb/vliw_dispatch_tb_top.sv
`timescale 1ns/1ps
module vliw_dispatch_tb_top;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         pkt_valid = 1'b0;
  logic         pkt_ready;
  logic [255:0] pkt_data = '0;
  logic         stall = 1'b0;
  logic         cr_we = 1'b0;
  logic [2:0]   cr_waddr = '0;
  logic [31:0]  cr_wdata = '0;
  logic [7:0]   iss_valid;
  logic [255:0] iss_instr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  vliw_dispatch dut_i (
    .clk(clk), .rst(rst), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_data(pkt_data), .stall(stall), .cr_we(cr_we), .cr_waddr(cr_waddr),
    .cr_wdata(cr_wdata), .iss_valid(iss_valid), .iss_instr(iss_instr)
  );

  task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // word: cond index, sense, tag byte, chaining bit
  function automatic logic [31:0] mk(input logic [2:0] cr, input logic z,
                                     input logic [7:0] tg, input logic ch);
    return {cr, z, 12'h000, tg, 7'h00, ch};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0]  m_pkt [8];
  logic [31:0]  m_cr  [8];
  bit           m_held = 0;
  int           m_start = 0;
  bit           m_on = 0;
  logic [7:0]   e_valid = '0;
  logic [255:0] e_instr = '0;
  bit           e_ready = 1;

  function automatic bit m_take(input logic [31:0] w);
    int idx;
    bit z;
    idx = int'(w[31:29]);
    if (idx == 0) return 1;
    z = (m_cr[idx] == 0);
    return w[28] ? z : !z;
  endfunction

  always @(posedge clk) begin
    m_on = 1;
    e_valid = '0;
    e_instr = '0;
    if (rst) begin
      m_held = 0;
      m_start = 0;
      for (int i = 0; i < 8; i++) m_cr[i] = '0;
    end else begin
      if (m_held && !stall) begin
        int e;
        e = m_start;
        while (e < 7 && m_pkt[e][0]) e++;
        for (int k = m_start; k <= e; k++) begin
          e_instr[k*32 +: 32] = m_pkt[k];
          e_valid[k] = m_take(m_pkt[k]);
        end
        if (e == 7) m_held = 0;
        else m_start = e + 1;
      end else if (!m_held && pkt_valid) begin
        for (int k = 0; k < 8; k++) m_pkt[k] = pkt_data[k*32 +: 32];
        m_held = 1;
        m_start = 0;
      end
      if (cr_we) m_cr[cr_waddr] = cr_wdata;
    end
    e_ready = !m_held;
  end

  always @(negedge clk) begin
    if (m_on) begin
      chk("R3 R5 R6 R7 R9 model valid", {248'h0, iss_valid}, {248'h0, e_valid});
      chk("R5 R8 model words", iss_instr, e_instr);
      chk("R2 R10 model ready", {255'h0, pkt_ready}, {255'h0, e_ready});
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      errors++;
      $display("FAIL R10 watchdog: actual %0d cycles expected below 50000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic send_pkt(input logic [255:0] d);
    do @(negedge clk); while (!pkt_ready);
    pkt_valid = 1'b1;
    pkt_data  = d;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic wr_cr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    cr_we = 1'b1; cr_waddr = a; cr_wdata = d;
    @(negedge clk);
    cr_we = 1'b0;
  endtask

  task automatic drain();
    while (!pkt_ready) @(negedge clk);
  endtask

  initial begin
    logic [255:0] p;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset valid", {248'h0, iss_valid}, 256'h0);
    chk("R1 reset words", iss_instr, 256'h0);
    chk("R1 reset ready", {255'h0, pkt_ready}, 256'h1);

    // R3: chaining 1,1,1,0,1,0,1,0
    for (int k = 0; k < 8; k++)
      p[k*32 +: 32] = mk(3'd0, 1'b0, 8'h10 + 8'(k), (k == 3 || k == 5 || k == 7) ? 1'b0 : 1'b1);
    send_pkt(p);
    chk("R2 ready low after accept", {255'h0, pkt_ready}, 256'h0);
    @(negedge clk);
    chk("R3 first set", {248'h0, iss_valid}, 256'h0F);
    chk("R5 words outside set zero", iss_instr, {128'h0, p[127:0]});
    chk("R2 ready low mid packet", {255'h0, pkt_ready}, 256'h0);
    @(negedge clk);
    chk("R3 second set", {248'h0, iss_valid}, 256'h30);
    @(negedge clk);
    chk("R3 third set", {248'h0, iss_valid}, 256'hC0);
    chk("R10 ready after last set", {255'h0, pkt_ready}, 256'h1);

    // R4: slot 7 chaining bit ignored
    for (int k = 0; k < 8; k++) p[k*32 +: 32] = mk(3'd0, 1'b0, 8'h20 + 8'(k), 1'b1);
    send_pkt(p);
    @(negedge clk);
    chk("R4 whole packet one set", {248'h0, iss_valid}, 256'hFF);
    chk("R10 ready after full set", {255'h0, pkt_ready}, 256'h1);

    // R6: stall holds position
    for (int k = 0; k < 8; k++) p[k*32 +: 32] = mk(3'd0, 1'b0, 8'h30 + 8'(k), 1'b0);
    send_pkt(p);
    stall = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R6 stalled valid", {248'h0, iss_valid}, 256'h0);
      chk("R6 stalled ready", {255'h0, pkt_ready}, 256'h0);
    end
    stall = 1'b0;
    @(negedge clk);
    chk("R6 resume slot 0", {248'h0, iss_valid}, 256'h01);
    @(negedge clk);
    chk("R6 resume slot 1", {248'h0, iss_valid}, 256'h02);
    stall = 1'b1;
    @(negedge clk);
    chk("R6 mid stall", {248'h0, iss_valid}, 256'h0);
    stall = 1'b0;
    @(negedge clk);
    chk("R6 keeps position", {248'h0, iss_valid}, 256'h04);
    drain();

    // R7 R8: predicates
    wr_cr(3'd2, 32'h0);
    wr_cr(3'd3, 32'h5);
    p[0*32 +: 32] = mk(3'd0, 1'b0, 8'h40, 1'b1);
    p[1*32 +: 32] = mk(3'd2, 1'b0, 8'h41, 1'b1);
    p[2*32 +: 32] = mk(3'd2, 1'b1, 8'h42, 1'b1);
    p[3*32 +: 32] = mk(3'd3, 1'b0, 8'h43, 1'b1);
    p[4*32 +: 32] = mk(3'd3, 1'b1, 8'h44, 1'b1);
    p[5*32 +: 32] = mk(3'd0, 1'b1, 8'h45, 1'b1);
    p[6*32 +: 32] = mk(3'd5, 1'b0, 8'h46, 1'b1);
    p[7*32 +: 32] = mk(3'd5, 1'b0, 8'h47, 1'b1);
    send_pkt(p);
    @(negedge clk);
    chk("R7 predicate mask", {248'h0, iss_valid}, 256'h2D);
    chk("R8 squashed word kept", {224'h0, iss_instr[63:32]}, {224'h0, p[63:32]});

    // R9: write on the issue edge
    p[0*32 +: 32] = mk(3'd4, 1'b0, 8'h50, 1'b0);
    for (int k = 1; k < 8; k++) p[k*32 +: 32] = mk(k == 1 ? 3'd4 : 3'd0, 1'b0, 8'h50 + 8'(k), 1'b1);
    send_pkt(p);
    cr_we = 1'b1; cr_waddr = 3'd4; cr_wdata = 32'h1;
    @(negedge clk);
    cr_we = 1'b0;
    chk("R9 same edge sees old value", {248'h0, iss_valid}, 256'h00);
    chk("R8 squashed slot 0 word", {224'h0, iss_instr[31:0]}, {224'h0, p[31:0]});
    @(negedge clk);
    chk("R9 next edge sees new value", {248'h0, iss_valid}, 256'hFE);

    // random collisions, judged by the model
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      stall    = ($urandom % 4) == 0;
      cr_we    = ($urandom % 3) == 0;
      cr_waddr = 3'($urandom);
      cr_wdata = (($urandom % 2) == 0) ? 32'h0 : $urandom;
      pkt_valid = ($urandom % 2) == 0;
      for (int k = 0; k < 8; k++)
        pkt_data[k*32 +: 32] = mk(3'($urandom), 1'($urandom), 8'($urandom), 1'($urandom));
    end
    @(negedge clk);
    stall = 1'b0; cr_we = 1'b0; pkt_valid = 1'b0;
    repeat (12) @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule